// File: doc/BRIEF.md
# Linked-List Block Mover

This block is a single-channel memory mover that walks a chain of descriptors held in system memory. Software loads the byte address of the first descriptor and writes a start bit through a four-entry register port. The engine then takes the system bus through a request/grant handshake. It reads each four-word descriptor, copies the words the descriptor asks for, and follows the link to the next descriptor. When it reaches a zero link, it releases the bus and raises a sticky completion flag.

Each transfer runs in one of two ways. It can run free at full speed. It can also be paced by a peripheral's request line, so that the device decides when each word moves. Two hold options keep the source or the destination address fixed, which lets a peripheral data register act as the source or the sink of a block. An abort input stops the chain at the next word boundary and hands the bus back.

Top module: `dma_chain_top`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_we and done are low, and the status register (address 2) reads zero.
- R2: A control write (address 1) with bit 0 set, made while idle, starts the chain at the address held in register 0 and raises bus_req. No memory access is made in any cycle where bus_gnt is low.
- R3: A descriptor is four consecutive words at a word-aligned byte address: byte count at +0, source at +4, destination at +8 and next link at +12. The four words are read in that order.
- R4: A descriptor moves count/4 words, one word per read-then-write, from source to destination. Both addresses step by 4 in ascending order. The two low bits of the count are ignored.
- R5: A descriptor whose count is below 4 moves nothing, and the engine goes straight on to its link.
- R6: After a descriptor finishes, the engine fetches the linked descriptor, with the two low bits of the link cleared. It stops when the whole 32-bit link is zero.
- R7: At the end of a chain, bus_req drops and done rises one cycle later. Status bit 1 mirrors done. Done stays set until a control write with bit 4 set.
- R8: When control bit 1 (pace) is set, each word's read waits for periph_req to be high. periph_ack pulses once, in the cycle of that word's write.
- R9: Control bit 2 holds the source address fixed for the whole descriptor, and control bit 3 holds the destination address fixed.
- R10: While busy, writes to register 0 and start requests are ignored. The running chain and the stored head address are unaffected.
- R11: A pulse on abort ends the chain after the word in flight: no further words are written, the bus is released, and done and status bit 2 (aborted) are set.
- R12: Status bit 0 reads 1 while the engine is busy. Register 3 reads the byte address of the descriptor in use, or the last one used.
- R13: Memory is synchronous: read data on mem_rdata is used in the cycle after mem_rd, and a write takes effect in the cycle mem_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 head, 1 control, 2 status, 3 current descriptor |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after mem_rd |
| periph_req | input | 1 | Peripheral pacing request |
| periph_ack | output | 1 | One pulse per word moved in paced mode |
| abort | input | 1 | Stop the chain at the next word boundary |
| done | output | 1 | Sticky chain-complete flag |

## Verification
The block has no free parameters; its address and data paths are fixed at 32 bits. The bench therefore builds it as it stands and limits its memory model to a 4 KiB window, with descriptors, sources and destinations in separate regions so that copies never overlap. A grant that arrives after a random delay, random pacing on the request line and randomly sized chains bring within reach the stalls in every access state, zero-length links and aborts that land at different points in a word.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int NUM_FIELDS = 4;
  localparam int FIELD_IW   = $clog2(NUM_FIELDS);
  localparam int CNT_W      = DATA_W - $clog2(WORD_BYTES);

  // descriptor word order (the fetch sequence depends on it)
  localparam logic [FIELD_IW-1:0] FLD_COUNT = 2'd0;
  localparam logic [FIELD_IW-1:0] FLD_SRC   = 2'd1;
  localparam logic [FIELD_IW-1:0] FLD_DST   = 2'd2;
  localparam logic [FIELD_IW-1:0] FLD_LINK  = 2'd3;

  // register port
  localparam logic [1:0] REG_HEAD   = 2'd0;
  localparam logic [1:0] REG_CTRL   = 2'd1;
  localparam logic [1:0] REG_STATUS = 2'd2;
  localparam logic [1:0] REG_CUR    = 2'd3;
  localparam int CB_START = 0;
  localparam int CB_PACE  = 1;
  localparam int CB_SHOLD = 2;
  localparam int CB_DHOLD = 3;
  localparam int CB_CLEAR = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_FRD, S_FCAP, S_SETUP,
    S_XWAIT, S_XCAP, S_XWR, S_NEXT, S_END
  } dma_state_e;

  function automatic logic [CNT_W-1:0] words_of(input logic [DATA_W-1:0] cnt);
    return cnt[DATA_W-1:DATA_W-CNT_W];
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input logic hold);
    return hold ? a : a + ADDR_W'(WORD_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] field_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [FIELD_IW-1:0] idx);
    return base + ADDR_W'({idx, 2'b00});
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic              abort_set,
  input  logic [ADDR_W-1:0] cur_desc,
  output logic [ADDR_W-1:0] head,
  output logic              start_go,
  output logic              pace,
  output logic              src_hold,
  output logic              dst_hold,
  output logic              done,
  output logic              aborted
);
  logic head_wr, ctrl_wr, clr_req;

  assign head_wr  = cfg_wr && (cfg_addr == REG_HEAD) && !busy;
  assign ctrl_wr  = cfg_wr && (cfg_addr == REG_CTRL);
  assign start_go = ctrl_wr && cfg_wdata[CB_START] && !busy;
  assign clr_req  = ctrl_wr && cfg_wdata[CB_CLEAR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head     <= '0;
      pace     <= 1'b0;
      src_hold <= 1'b0;
      dst_hold <= 1'b0;
      done     <= 1'b0;
      aborted  <= 1'b0;
    end else begin
      if (head_wr) head <= word_align(cfg_wdata);
      if (ctrl_wr && !busy) begin
        pace     <= cfg_wdata[CB_PACE];
        src_hold <= cfg_wdata[CB_SHOLD];
        dst_hold <= cfg_wdata[CB_DHOLD];
      end
      if (done_set)     done <= 1'b1;
      else if (clr_req) done <= 1'b0;
      if (abort_set)    aborted <= 1'b1;
      else if (clr_req) aborted <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg_addr)
      REG_HEAD:   cfg_rdata = head;
      REG_CTRL:   cfg_rdata = {{(DATA_W-4){1'b0}}, dst_hold, src_hold, pace, 1'b0};
      REG_STATUS: cfg_rdata = {{(DATA_W-3){1'b0}}, aborted, done, busy};
      default:    cfg_rdata = cur_desc;
    endcase
  end
endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_chain_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fld_load,
  input  logic [FIELD_IW-1:0] fld_idx,
  input  logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   cnt,
  output logic [ADDR_W-1:0]   src,
  output logic [ADDR_W-1:0]   dst,
  output logic [ADDR_W-1:0]   link
);
  logic [DATA_W-1:0] fld_q [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)                                    fld_q[g] <= '0;
      else if (fld_load && fld_idx == FIELD_IW'(g))  fld_q[g] <= rdata;
    end
  end

  assign cnt  = fld_q[FLD_COUNT];
  assign src  = fld_q[FLD_SRC];
  assign dst  = fld_q[FLD_DST];
  assign link = fld_q[FLD_LINK];
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              cap,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [DATA_W-1:0] cnt_in,
  input  logic              src_hold,
  input  logic              dst_hold,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] src_cur,
  output logic [ADDR_W-1:0] dst_cur,
  output logic [CNT_W-1:0]  words_left,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_cur    <= '0;
      dst_cur    <= '0;
      words_left <= '0;
      data_q     <= '0;
    end else begin
      if (load) begin
        src_cur    <= src_in;
        dst_cur    <= dst_in;
        words_left <= words_of(cnt_in);
      end else if (step) begin
        src_cur    <= step_addr(src_cur, src_hold);
        dst_cur    <= step_addr(dst_cur, dst_hold);
        words_left <= words_left - CNT_W'(1);
      end
      if (cap) data_q <= rdata;
    end
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_chain_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_go,
  input  logic [ADDR_W-1:0]   head,
  input  logic                pace,
  input  logic                bus_gnt,
  input  logic                periph_req,
  input  logic                abort,
  input  logic [DATA_W-1:0]   desc_cnt,
  input  logic [ADDR_W-1:0]   desc_link,
  input  logic [CNT_W-1:0]    words_left,
  input  logic [ADDR_W-1:0]   src_cur,
  input  logic [ADDR_W-1:0]   dst_cur,
  output logic                bus_req,
  output logic                mem_rd,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                fld_load,
  output logic [FIELD_IW-1:0] fld_idx,
  output logic                xfer_load,
  output logic                word_cap,
  output logic                word_done,
  output logic                data_phase,
  output logic                periph_ack,
  output logic                busy,
  output logic                done_set,
  output logic                abort_set,
  output logic [ADDR_W-1:0]   cur_desc
);
  dma_state_e state, state_nx;
  logic abort_pend, stop;
  logic fetch_issue, rd_issue, wr_issue;

  assign stop        = abort_pend | abort;
  assign fetch_issue = (state == S_FRD) && bus_gnt;
  assign data_phase  = (state == S_XWAIT);
  assign rd_issue    = data_phase && bus_gnt && !stop && (!pace || periph_req);
  assign wr_issue    = (state == S_XWR) && bus_gnt;

  assign mem_rd     = fetch_issue | rd_issue;
  assign mem_we     = wr_issue;
  assign fld_load   = (state == S_FCAP);
  assign xfer_load  = (state == S_SETUP);
  assign word_cap   = (state == S_XCAP);
  assign word_done  = wr_issue;
  assign periph_ack = wr_issue && pace;
  assign busy       = (state != S_IDLE);
  assign bus_req    = busy && (state != S_END);
  assign done_set   = (state == S_END);
  assign abort_set  = (state == S_END) && abort_pend;

  always_comb begin
    unique case (state)
      S_XWR:   mem_addr = dst_cur;
      S_XWAIT: mem_addr = src_cur;
      default: mem_addr = field_addr(cur_desc, fld_idx);
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (start_go) state_nx = S_REQ;
      S_REQ:   if (stop) state_nx = S_END;
               else if (bus_gnt) state_nx = S_FRD;
      S_FRD:   if (fetch_issue) state_nx = S_FCAP;
      S_FCAP:  if (stop) state_nx = S_END;
               else if (fld_idx == FLD_LINK) state_nx = S_SETUP;
               else state_nx = S_FRD;
      S_SETUP: if (stop) state_nx = S_END;
               else if (words_of(desc_cnt) == '0) state_nx = S_NEXT;
               else state_nx = S_XWAIT;
      S_XWAIT: if (stop) state_nx = S_END;
               else if (rd_issue) state_nx = S_XCAP;
      S_XCAP:  state_nx = S_XWR;
      S_XWR:   if (wr_issue) state_nx = (words_left == CNT_W'(1)) ? S_NEXT : S_XWAIT;
      S_NEXT:  if (stop || desc_link == '0) state_nx = S_END;
               else state_nx = S_FRD;
      S_END:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      fld_idx    <= '0;
      cur_desc   <= '0;
      abort_pend <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE || state == S_END) abort_pend <= 1'b0;
      else if (abort)                        abort_pend <= 1'b1;
      if (state == S_IDLE && start_go) begin
        cur_desc <= head;
        fld_idx  <= FLD_COUNT;
      end else if (state == S_FCAP && fld_idx != FLD_LINK) begin
        fld_idx <= fld_idx + FIELD_IW'(1);
      end else if (state == S_NEXT && state_nx == S_FRD) begin
        cur_desc <= word_align(desc_link);
        fld_idx  <= FLD_COUNT;
      end
    end
  end
endmodule

// File: rtl/dma_chain_top.sv
module dma_chain_top
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              periph_req,
  output logic              periph_ack,
  input  logic              abort,
  output logic              done
);
  logic [ADDR_W-1:0]   head, cur_desc, src_cur, dst_cur, d_src, d_dst, d_link;
  logic [DATA_W-1:0]   d_cnt;
  logic [CNT_W-1:0]    words_left;
  logic [FIELD_IW-1:0] fld_idx;
  logic start_go, pace, src_hold, dst_hold, aborted;
  logic busy, done_set, abort_set, fld_load, xfer_load, word_cap, word_done, data_phase;

  dma_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .done_set(done_set), .abort_set(abort_set), .cur_desc(cur_desc),
    .head(head), .start_go(start_go), .pace(pace), .src_hold(src_hold),
    .dst_hold(dst_hold), .done(done), .aborted(aborted)
  );

  dma_desc_regs u_desc (
    .clk(clk), .rst_n(rst_n), .fld_load(fld_load), .fld_idx(fld_idx),
    .rdata(mem_rdata), .cnt(d_cnt), .src(d_src), .dst(d_dst), .link(d_link)
  );

  dma_mover u_mover (
    .clk(clk), .rst_n(rst_n), .load(xfer_load), .cap(word_cap), .step(word_done),
    .src_in(d_src), .dst_in(d_dst), .cnt_in(d_cnt), .src_hold(src_hold),
    .dst_hold(dst_hold), .rdata(mem_rdata), .src_cur(src_cur), .dst_cur(dst_cur),
    .words_left(words_left), .data_q(mem_wdata)
  );

  dma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .head(head), .pace(pace),
    .bus_gnt(bus_gnt), .periph_req(periph_req), .abort(abort),
    .desc_cnt(d_cnt), .desc_link(d_link), .words_left(words_left),
    .src_cur(src_cur), .dst_cur(dst_cur), .bus_req(bus_req), .mem_rd(mem_rd),
    .mem_we(mem_we), .mem_addr(mem_addr), .fld_load(fld_load), .fld_idx(fld_idx),
    .xfer_load(xfer_load), .word_cap(word_cap), .word_done(word_done),
    .data_phase(data_phase), .periph_ack(periph_ack), .busy(busy),
    .done_set(done_set), .abort_set(abort_set), .cur_desc(cur_desc)
  );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk
  import dma_chain_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_rd,
  input logic              mem_we,
  input logic              periph_req,
  input logic              periph_ack,
  input logic              done,
  input logic              cfg_wr,
  input logic [1:0]        cfg_addr,
  input logic              busy,
  input logic              pace,
  input logic              data_phase,
  input logic              aborted,
  input logic [ADDR_W-1:0] head
);
  p_access_needs_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_we) |-> (bus_req && bus_gnt));

  p_one_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_we && !bus_req));

  p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |=> done);

  p_paced_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && data_phase && pace) |-> periph_req);

  p_ack_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> (mem_we && pace));

  p_head_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr && cfg_addr == REG_HEAD) |=> $stable(head));

  p_abort_implies_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted) |-> done);
endmodule

bind dma_chain_top dma_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_rd(mem_rd), .mem_we(mem_we), .periph_req(periph_req),
  .periph_ack(periph_ack), .done(done), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .busy(busy), .pace(pace), .data_phase(data_phase), .aborted(aborted),
  .head(head)
);

// File: tb/test_dma_chain_top.sv
module test_dma_chain_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic bus_req, bus_gnt = 1'b0, mem_rd, mem_we, periph_ack, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic periph_req = 1'b0, abort = 1'b0;

  int n_checks = 0, n_fail = 0;
  int n_wr = 0, n_ack = 0, bad_access = 0;
  int preq_mode = 0;
  logic [31:0] mem [1024];
  logic [31:0] exp_mem [1024];

  always #5 clk = ~clk;

  dma_chain_top i_dma_chain_top (.*);

  // synchronous memory model and bus monitors
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
    if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; n_wr <= n_wr + 1; end
    if ((mem_rd || mem_we) && !bus_gnt) bad_access <= bad_access + 1;
    if (periph_ack) n_ack <= n_ack + 1;
  end

  // grant with random latency
  initial begin
    int gdly = 0;
    forever begin
      @(negedge clk);
      if (!bus_req) begin bus_gnt = 1'b0; gdly = $urandom % 4; end
      else if (gdly == 0) bus_gnt = 1'b1;
      else gdly--;
    end
  end

  // peripheral pacing: 0 low, 1 high, 2 random
  initial forever begin
    @(negedge clk);
    periph_req = (preq_mode == 1) || (preq_mode == 2 && ($urandom % 3 == 0));
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  task automatic wr_cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd_cfg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, s, d, n);
    mem[a/4] = c; mem[a/4+1] = s; mem[a/4+2] = d; mem[a/4+3] = n;
  endtask

  task automatic fill(input int a, input int words);
    for (int i = 0; i < words; i++) mem[a/4 + i] = $urandom;
  endtask

  task automatic snap();
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
  endtask

  // reference walk of the chain over the expected image
  task automatic model_chain(input logic [31:0] hd, input bit sh, input bit dh);
    logic [31:0] p = hd;
    for (int g = 0; g < 32; g++) begin
      logic [31:0] c = exp_mem[p[11:2]], s = exp_mem[p[11:2]+1];
      logic [31:0] d = exp_mem[p[11:2]+2], n = exp_mem[p[11:2]+3];
      for (int w = 0; w < int'(c >> 2); w++) begin
        exp_mem[d[11:2]] = exp_mem[s[11:2]];
        if (!sh) s += 4;
        if (!dh) d += 4;
      end
      if (n == 0) break;
      p = {n[31:2], 2'b00};
    end
  endtask

  function automatic int mem_diffs();
    int e = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) e++;
    return e;
  endfunction

  task automatic run(input logic [31:0] hd, input logic [31:0] ctrl);
    wr_cfg(2'd0, hd);
    wr_cfg(2'd1, ctrl | 32'h1);
    wait_done();
  endtask

  task automatic clear_done();
    wr_cfg(2'd1, 32'h10);
  endtask

  initial begin
    logic [31:0] r;
    int base, k;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'hdead_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_cfg(2'd2, r);
    check(r == 0 && !bus_req && !done && !mem_rd && !mem_we, "R1 reset state", r, 0);

    // R2 R3 R4 R12 single descriptor, count low bits ignored
    fill(32'h400, 8);
    put_desc(32'h100, 32'd35, 32'h400, 32'h800, 32'h0);
    snap(); model_chain(32'h100, 0, 0);
    wr_cfg(2'd0, 32'h100);
    wr_cfg(2'd1, 32'h1);
    rd_cfg(2'd2, r);
    check(r[0] == 1'b1, "R12 busy while running", r, 1);
    check(bus_req == 1'b1, "R2 bus_req during run", bus_req, 1);
    wait_done();
    check(mem_diffs() == 0, "R4 R3 single copy", mem_diffs(), 0);
    check(bad_access == 0, "R2 no access without grant", bad_access, 0);
    rd_cfg(2'd2, r);
    check(done && r[1] && !bus_req, "R7 done and bus released", r, 2);
    rd_cfg(2'd3, r);
    check(r == 32'h100, "R12 current descriptor", r, 32'h100);
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R7 done sticky", done, 1);
    clear_done();
    check(done == 1'b0, "R7 done cleared", done, 0);

    // R5 R6 chain with zero-length middle and untidy link
    fill(32'h400, 16); fill(32'h500, 12);
    put_desc(32'h100, 32'd16, 32'h400, 32'h800, 32'h141);
    put_desc(32'h140, 32'd3, 32'h440, 32'h840, 32'h180);
    put_desc(32'h180, 32'd48, 32'h500, 32'h900, 32'h0);
    snap(); model_chain(32'h100, 0, 0);
    run(32'h100, 0);
    check(mem_diffs() == 0, "R5 R6 chain copy", mem_diffs(), 0);
    rd_cfg(2'd3, r);
    check(r == 32'h180, "R6 last descriptor", r, 32'h180);
    clear_done();

    // R8 paced transfer
    preq_mode = 2;
    fill(32'h400, 10);
    put_desc(32'h100, 32'd40, 32'h400, 32'hA00, 32'h0);
    snap(); model_chain(32'h100, 0, 0);
    base = n_ack;
    run(32'h100, 32'h2);
    check(n_ack - base == 10, "R8 one ack per word", n_ack - base, 10);
    check(mem_diffs() == 0, "R8 paced copy", mem_diffs(), 0);
    clear_done();
    preq_mode = 0;

    // R9 fixed source, then fixed destination
    fill(32'h600, 5);
    put_desc(32'h100, 32'd20, 32'h600, 32'hB00, 32'h0);
    snap(); model_chain(32'h100, 1, 0);
    run(32'h100, 32'h4);
    check(mem_diffs() == 0, "R9 source held", mem_diffs(), 0);
    clear_done();
    put_desc(32'h100, 32'd20, 32'h600, 32'hB80, 32'h0);
    snap(); model_chain(32'h100, 0, 1);
    run(32'h100, 32'h8);
    check(mem_diffs() == 0, "R9 destination held", mem_diffs(), 0);
    clear_done();

    // R10 head write and restart while busy
    fill(32'h400, 6);
    put_desc(32'h100, 32'd24, 32'h400, 32'hC00, 32'h0);
    put_desc(32'h1C0, 32'd8, 32'h400, 32'hD00, 32'h0);
    snap(); model_chain(32'h100, 0, 0);
    base = n_wr;
    wr_cfg(2'd0, 32'h100);
    wr_cfg(2'd1, 32'h3);
    repeat (20) @(negedge clk);
    wr_cfg(2'd0, 32'h1C0);
    wr_cfg(2'd1, 32'h1);
    rd_cfg(2'd0, r);
    check(r == 32'h100, "R10 head kept while busy", r, 32'h100);
    preq_mode = 1;
    wait_done();
    check(mem_diffs() == 0 && n_wr - base == 6, "R10 second start ignored", n_wr - base, 6);
    clear_done();
    preq_mode = 0;

    // R11 abort while waiting on pacing
    put_desc(32'h100, 32'd16, 32'h400, 32'hE00, 32'h0);
    snap();
    base = n_wr;
    wr_cfg(2'd0, 32'h100);
    wr_cfg(2'd1, 32'h3);
    repeat (30) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_done();
    rd_cfg(2'd2, r);
    check(n_wr - base == 0 && mem_diffs() == 0, "R11 no word after abort", n_wr - base, 0);
    check(r[2] && r[1] && !bus_req, "R11 aborted flag and release", r, 6);
    clear_done();

    // R11 abort in the middle of a free-running block
    fill(32'h400, 64);
    put_desc(32'h100, 32'd256, 32'h400, 32'hE00, 32'h0);
    snap();
    base = n_wr;
    wr_cfg(2'd0, 32'h100);
    wr_cfg(2'd1, 32'h1);
    while (n_wr - base < 5) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_done();
    k = n_wr - base;
    check(k >= 5 && k <= 6, "R11 stops after current word", k, 5);
    for (int i = 0; i < k; i++) exp_mem[32'hE00/4 + i] = exp_mem[32'h400/4 + i];
    check(mem_diffs() == 0, "R11 partial copy only", mem_diffs(), 0);
    clear_done();

    // R4 R6 R8 random chains
    for (int t = 0; t < 4; t++) begin
      int nd = 1 + $urandom % 3;
      bit pc = $urandom % 2;
      preq_mode = pc ? 2 : 0;
      for (int j = 0; j < nd; j++) begin
        int cnt = ($urandom % 17) * 4 + ($urandom % 4);
        fill(32'h400 + 64*j, 16);
        put_desc(32'h100 + 32*j, cnt, 32'h400 + 64*j, 32'h800 + 64*j + 256*t,
                 (j == nd-1) ? 32'h0 : 32'h100 + 32*(j+1));
      end
      snap(); model_chain(32'h100, 0, 0);
      run(32'h100, pc ? 32'h2 : 32'h0);
      check(mem_diffs() == 0 && done, "R4 R6 random chain", mem_diffs(), 0);
      clear_done();
    end
    check(bad_access == 0, "R2 grant respected overall", bad_access, 0);
    finish_run();
  end
endmodule